// File: doc/BRIEF.md
# Flash Row Write-Latch Controller

This block sits between a CPU-style byte bus and a behavioural flash array. It owns a small control register and a 16-byte write buffer. Software arms latch access, writes up to sixteen bytes into the flash address range (each byte lands in the buffer slot picked by the low four address bits), then sets the program bit. The controller then runs a timed programming cycle and, at its end, writes only the bytes that were actually loaded into the row named by the most recent write. When the cycle ends, hardware drops both the program and latch-access bits and empties the buffer.

While a cycle runs, the flash range cannot be read: such reads return FFh and the `busy` output is high. Control-register writes are ignored during that time, so latch access cannot be withdrawn mid-cycle. With the option-area bit set, the flash range is redirected to a separate two-byte option store: reads return option byte `addr[0]`, and a programming cycle commits buffer slots 0 and 1 into that store instead of the main array.

The cycle length is a parameter in clock cycles (`PROG_CYCLES`). On real parts it is several milliseconds; the parameter lets simulation use a short value.

Top module: `flash_row_latch_ctrl`

## Requirements
- R1: After reset the control register reads 00h, `busy` is 0, and every main-array byte and both option bytes read FFh.
- R2: The control register sits at `CSR_ADDR`. Bit 2 is option-area select, bit 1 is latch access, and bit 0 is program/busy. Bits 7:3 always read 0; writing FEh while idle reads back 06h.
- R3: While latch access is 0, writes to the flash range change nothing, and flash reads return the array contents.
- R4: While latch access is 1 and no cycle runs, a flash-range write stores its byte in buffer slot `addr[3:0]`. The array is not changed until a programming cycle ends.
- R5: The target row of a cycle is `addr[15:4]` of the last buffered write, whatever rows earlier buffered writes named.
- R6: A cycle writes only the slots loaded since the last cycle. The other bytes of the row keep their values.
- R7: A control write with bit 0 = 1 and bit 1 = 1 starts a cycle. Bit 0 and `busy` then read 1 for exactly `PROG_CYCLES` clock cycles.
- R8: A control write with bit 0 = 1 and bit 1 = 0 starts no cycle, and bit 0 reads 0.
- R9: When a cycle ends, program and latch access clear, option select is kept, and all slots are emptied. A following cycle with no new writes changes nothing.
- R10: Control-register writes during a cycle are ignored, including an attempt to clear latch access.
- R11: During a cycle, flash-range reads return FFh and flash-range writes are ignored. This includes a write on the final busy cycle.
- R12: With option select at 1, flash-range reads return option byte `addr[0]`. A cycle writes slots 0 and 1 into the option store and leaves the main array untouched.
- R13: Reads of addresses that are neither the control register nor the flash range return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| busy | output | 1 | Programming cycle in progress |

## Verification
The delicate overlap is the end of a programming cycle meeting a bus access in the same clock: the commit, the hardware clear of the control bits and the emptying of the buffer all happen on the edge where a new write might also be captured. The bench starts a cycle and counts down to the last busy cycle. There it reads the target byte, expecting FFh, then drives a flash write that is sampled on the commit edge. After that edge the committed byte must be visible, the late byte must still read FFh, and the control register must read 00h.

// File: rtl/frl_pkg.sv
package frl_pkg;
  localparam int LANES     = 16;
  localparam int LANE_BITS = 4;
  localparam int ROW_AW    = 12;
  localparam int OPT_BYTES = 2;

  localparam int CSR_PGM_BIT = 0;
  localparam int CSR_LAT_BIT = 1;
  localparam int CSR_OPT_BIT = 2;

  typedef logic [7:0] byte_t;
endpackage

// File: rtl/frl_latch_buf.sv
module frl_latch_buf
  import frl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [LANE_BITS-1:0]       wr_idx,
  input  byte_t                      wr_data,
  input  logic [ROW_AW-1:0]          wr_row,
  input  logic                       clr,
  output logic [LANES-1:0][7:0]      slot_data,
  output logic [LANES-1:0]           slot_valid,
  output logic [ROW_AW-1:0]          row_q
);
  logic [ROW_AW-1:0] row_d;

  always_comb begin
    row_d = row_q;
    if (wr_en) row_d = wr_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  for (genvar s = 0; s < LANES; s++) begin : g_slot
    logic  hit;
    logic  v_d;
    byte_t d_d;
    assign hit = wr_en && (wr_idx == LANE_BITS'(s));

    always_comb begin
      v_d = slot_valid[s];
      d_d = slot_data[s];
      if (clr) begin
        v_d = 1'b0;
        d_d = 8'hFF;
      end else if (hit) begin
        v_d = 1'b1;
        d_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_valid[s] <= 1'b0;
        slot_data[s]  <= 8'hFF;
      end else begin
        slot_valid[s] <= v_d;
        slot_data[s]  <= d_d;
      end
    end
  end
endmodule

// File: rtl/frl_prog_timer.sv
module frl_prog_timer #(
  parameter int PROG_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d;

  assign done = busy && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(PROG_CYCLES - 1);
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end
endmodule

// File: rtl/frl_store.sv
module frl_store
  import frl_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int ROW_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic                  commit_opt,
  input  logic [ROW_BITS-1:0]   commit_row,
  input  logic [LANES-1:0][7:0] slot_data,
  input  logic [LANES-1:0]      slot_valid,
  input  logic [ROW_BITS-1:0]   rd_row,
  input  logic [LANE_BITS-1:0]  rd_lane,
  input  logic                  rd_opt_idx,
  output byte_t                 arr_rdata,
  output byte_t                 opt_rdata
);
  byte_t lane_rd [LANES];
  byte_t opt_q   [OPT_BYTES];

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    byte_t mem [ROWS];
    logic  we;
    assign we = commit && !commit_opt && slot_valid[c];
    assign lane_rd[c] = mem[rd_row];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < ROWS; r++) mem[r] <= 8'hFF;
      end else if (we) begin
        mem[commit_row] <= slot_data[c];
      end
    end
  end

  for (genvar o = 0; o < OPT_BYTES; o++) begin : g_opt
    logic ow;
    assign ow = commit && commit_opt && slot_valid[o];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  opt_q[o] <= 8'hFF;
      else if (ow) opt_q[o] <= slot_data[o];
    end
  end

  assign arr_rdata = lane_rd[rd_lane];
  assign opt_rdata = opt_q[rd_opt_idx];
endmodule

// File: rtl/flash_row_latch_ctrl.sv
module flash_row_latch_ctrl
  import frl_pkg::*;
#(
  parameter logic [15:0] FLASH_BASE  = 16'hE000,
  parameter int          ROWS        = 16,
  parameter logic [15:0] CSR_ADDR    = 16'h0026,
  parameter int          PROG_CYCLES = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        busy
);
  localparam int          ROW_BITS    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [15:0] FLASH_BYTES = 16'(ROWS * LANES);

  logic opt_q, opt_d, lat_q, lat_d;
  logic prog_done, prog_start;
  logic csr_hit, in_flash, csr_wr, latch_wr, rd_flash;
  logic [15:0] off;
  logic [ROW_AW-1:0] row_q, row_off;
  logic [LANES-1:0][7:0] lat_data;
  logic [LANES-1:0] lat_valid;
  byte_t arr_rdata, opt_rdata;

  // address decode
  assign off      = bus_addr - FLASH_BASE;
  assign in_flash = (bus_addr >= FLASH_BASE) && (off < FLASH_BYTES);
  assign csr_hit  = (bus_addr == CSR_ADDR);
  assign csr_wr   = bus_sel && bus_we && csr_hit && !busy;
  assign latch_wr = bus_sel && bus_we && in_flash && lat_q && !busy;
  assign rd_flash = bus_sel && !bus_we && in_flash;
  assign prog_start = csr_wr && bus_wdata[CSR_PGM_BIT] && bus_wdata[CSR_LAT_BIT];
  assign row_off  = row_q - FLASH_BASE[15:4];

  // control register next state
  always_comb begin
    opt_d = opt_q;
    lat_d = lat_q;
    if (prog_done) begin
      lat_d = 1'b0;
    end else if (csr_wr) begin
      opt_d = bus_wdata[CSR_OPT_BIT];
      lat_d = bus_wdata[CSR_LAT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      opt_q <= opt_d;
      lat_q <= lat_d;
    end
  end

  frl_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (prog_start),
    .busy  (busy),
    .done  (prog_done)
  );

  frl_latch_buf i_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (latch_wr),
    .wr_idx     (bus_addr[LANE_BITS-1:0]),
    .wr_data    (bus_wdata),
    .wr_row     (bus_addr[15:4]),
    .clr        (prog_done),
    .slot_data  (lat_data),
    .slot_valid (lat_valid),
    .row_q      (row_q)
  );

  frl_store #(.ROWS(ROWS), .ROW_BITS(ROW_BITS)) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (prog_done),
    .commit_opt (opt_q),
    .commit_row (row_off[ROW_BITS-1:0]),
    .slot_data  (lat_data),
    .slot_valid (lat_valid),
    .rd_row     (off[ROW_BITS+3:4]),
    .rd_lane    (off[3:0]),
    .rd_opt_idx (bus_addr[0]),
    .arr_rdata  (arr_rdata),
    .opt_rdata  (opt_rdata)
  );

  // read mux
  always_comb begin
    bus_rdata = 8'h00;
    if (bus_sel && !bus_we) begin
      if (csr_hit)       bus_rdata = {5'b0, opt_q, lat_q, busy};
      else if (rd_flash) bus_rdata = busy ? 8'hFF : (opt_q ? opt_rdata : arr_rdata);
    end
  end
endmodule

// File: rtl/frl_checker.sv
module frl_checker
  import frl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             lat,
  input logic [LANES-1:0] valid,
  input logic             rd_flash,
  input logic [7:0]       rdata
);
  assert_busy_read_ff_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_flash) |-> (rdata == 8'hFF));

  assert_end_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !lat && (valid == '0)));

  assert_lat_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> lat);

  assert_slots_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(valid));

  assert_start_needs_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> lat);
endmodule

bind flash_row_latch_ctrl frl_checker i_frl_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (prog_done),
  .lat      (lat_q),
  .valid    (lat_valid),
  .rd_flash (rd_flash),
  .rdata    (bus_rdata)
);

// File: tb/test_flash_row_latch_ctrl.sv
`timescale 1ns/1ps
module test_flash_row_latch_ctrl;
  localparam int          PC  = 12;
  localparam logic [15:0] CSR = 16'h0026;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_we;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic busy;
  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  flash_row_latch_ctrl #(.PROG_CYCLES(PC)) i_flash_row_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // run a cycle from idle to end (call right after the start write)
  task automatic run_cycle(input string tag);
    idle(PC - 1);
    check({tag, " busy last cycle"}, {7'b0, busy}, 8'h01);
    idle(1);
    check({tag, " busy after end"}, {7'b0, busy}, 8'h00);
  endtask

  task automatic t_reset;
    check("R1 busy", {7'b0, busy}, 8'h00);
    rd(CSR, rv);     check("R1 csr", rv, 8'h00);
    rd(16'hE000, rv); check("R1 array E000", rv, 8'hFF);
    rd(16'hE0FF, rv); check("R1 array E0FF", rv, 8'hFF);
    wr(CSR, 8'h04);
    rd(16'hE000, rv); check("R1 opt0", rv, 8'hFF);
    rd(16'hE001, rv); check("R1 opt1", rv, 8'hFF);
    wr(CSR, 8'h00);
  endtask

  task automatic t_csr_fields;
    wr(CSR, 8'hFE);
    rd(CSR, rv); check("R2 reserved bits", rv, 8'h06);
    check("R2 no start", {7'b0, busy}, 8'h00);
    wr(CSR, 8'h00);
    rd(CSR, rv); check("R2 cleared", rv, 8'h00);
  endtask

  task automatic t_lat_off;
    wr(16'hE010, 8'h55);
    rd(16'hE010, rv); check("R3 write ignored", rv, 8'hFF);
    wr(CSR, 8'h03);
    idle(PC + 2);
    rd(16'hE010, rv); check("R3 nothing buffered", rv, 8'hFF);
  endtask

  task automatic t_partial;
    wr(CSR, 8'h02);
    wr(16'hE020, 8'h11);
    wr(16'hE025, 8'h22);
    wr(16'hE02F, 8'h33);
    rd(16'hE025, rv); check("R4 not yet in array", rv, 8'hFF);
    wr(CSR, 8'h03);
    check("R7 busy set", {7'b0, busy}, 8'h01);
    rd(CSR, rv); check("R7 csr busy", rv, 8'h03);
    run_cycle("R7");
    rd(CSR, rv); check("R9 csr after end", rv, 8'h00);
    rd(16'hE020, rv); check("R4 slot0", rv, 8'h11);
    rd(16'hE025, rv); check("R4 slot5", rv, 8'h22);
    rd(16'hE02F, rv); check("R4 slotF", rv, 8'h33);
    rd(16'hE021, rv); check("R6 unloaded slot", rv, 8'hFF);
  endtask

  task automatic t_row_last;
    wr(CSR, 8'h02);
    wr(16'hE031, 8'hAA);
    wr(16'hE047, 8'hBB);
    wr(CSR, 8'h03);
    run_cycle("R5");
    rd(16'hE041, rv); check("R5 early byte to last row", rv, 8'hAA);
    rd(16'hE047, rv); check("R5 last byte", rv, 8'hBB);
    rd(16'hE031, rv); check("R5 earlier row untouched", rv, 8'hFF);
  endtask

  task automatic t_no_lat_start;
    wr(CSR, 8'h01);
    check("R8 no busy", {7'b0, busy}, 8'h00);
    rd(CSR, rv); check("R8 csr", rv, 8'h00);
  endtask

  task automatic t_busy_block;
    wr(CSR, 8'h02);
    wr(16'hE020, 8'h99);
    wr(CSR, 8'h03);
    rd(16'hE020, rv); check("R11 read blocked", rv, 8'hFF);
    wr(CSR, 8'h00);
    rd(CSR, rv); check("R10 csr write ignored", rv, 8'h03);
    wr(16'hE02A, 8'h77);
    idle(PC);
    check("R10 cycle ended", {7'b0, busy}, 8'h00);
    rd(16'hE020, rv); check("R10 committed", rv, 8'h99);
    rd(16'hE02A, rv); check("R11 busy write ignored", rv, 8'hFF);
    wr(CSR, 8'h02);
    wr(CSR, 8'h03);
    run_cycle("R9");
    rd(16'hE020, rv); check("R9 empty cycle no change", rv, 8'h99);
  endtask

  task automatic t_end_overlap;
    wr(CSR, 8'h02);
    wr(16'hE050, 8'h5A);
    wr(CSR, 8'h03);
    idle(PC - 1);
    rd(16'hE050, rv); check("R11 last busy read", rv, 8'hFF);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 16'hE05B; bus_wdata = 8'hC3;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check("R11 ended", {7'b0, busy}, 8'h00);
    rd(16'hE050, rv); check("R6 committed at end", rv, 8'h5A);
    rd(16'hE05B, rv); check("R11 write on end edge ignored", rv, 8'hFF);
    rd(CSR, rv); check("R9 csr cleared", rv, 8'h00);
  endtask

  task automatic t_option;
    wr(CSR, 8'h06);
    wr(16'hE000, 8'hC5);
    wr(16'hE001, 8'h6D);
    wr(16'hE002, 8'h12);
    wr(CSR, 8'h07);
    run_cycle("R12");
    rd(CSR, rv); check("R9 opt kept", rv, 8'h04);
    rd(16'hE000, rv); check("R12 opt0", rv, 8'hC5);
    rd(16'hE001, rv); check("R12 opt1", rv, 8'h6D);
    wr(CSR, 8'h00);
    rd(16'hE000, rv); check("R12 main untouched 0", rv, 8'hFF);
    rd(16'hE002, rv); check("R12 main untouched 2", rv, 8'hFF);
  endtask

  task automatic t_unmapped;
    rd(16'h1234, rv); check("R13 unmapped", rv, 8'h00);
    rd(16'hE100, rv); check("R13 past array", rv, 8'h00);
    rd(16'hDFFF, rv); check("R13 below array", rv, 8'h00);
  endtask

  initial begin
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_csr_fields();
    t_lat_off();
    t_partial();
    t_row_last();
    t_no_lat_start();
    t_busy_block();
    t_end_overlap();
    t_option();
    t_unmapped();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule